// File: doc/BRIEF.md
# Single-contact bus slave bit-level front end

This block is the physical layer of a slave on a single-wire, open-drain bus whose master starts every time slot with a falling edge. It runs from a free-running clock. All of its timing is given as clock counts. It filters the incoming line and measures each low pulse. A long enough pulse counts as a bus reset and triggers a presence response. Shorter pulses are time slots, and in each one the line is sampled a fixed time after the master's falling edge. The result is handed upward as one bit per slot.

The layer above controls the rest. It marks the coming slot as a read and supplies the bit to send. For a zero, the block holds the line low for a hold time after the master's edge; for a one it leaves the line released. The layer above can also put the slave into the fast timing set. A reset then either keeps that speed or returns to standard speed, depending on how long the line was held low.

Top module: `scb_slave_phy`

## Requirements
- R1: After `rst_n` is released, `od_mode`, `ready` and `bus_drive_low` are 0, and no `slot_valid` appears until a bus reset completes.
- R2: A low pulse of `RST_LONG` (480) cycles or more is a bus reset: `rst_seen` pulses once and `od_mode` becomes 0. At standard speed a pulse of `RST_LONG-1` cycles is not a reset.
- R3: At fast speed, a low pulse from `OD_RST_MIN` (48) up to and including `OD_KEEP` (80) cycles is a bus reset that leaves `od_mode` at 1.
- R4: At fast speed, a low pulse longer than `OD_KEEP` and shorter than `RST_LONG` is a bus reset that returns `od_mode` to 0. A pulse of `OD_RST_MIN-1` cycles is a slot, not a reset.
- R5: After the line returns high at the end of a reset, `bus_drive_low` rises `SYNC+FILT+2+PDH` cycles after the release and stays high for exactly `PDL` cycles. `PDH`/`PDL` are 30/120 at standard speed and 3/12 at fast speed, picked by the speed in force after the reset.
- R6: `ready` is 0 while the presence sequence runs. It rises `REC` cycles after the presence pulse ends. A falling edge while `ready` is 0 produces no slot.
- R7: Each master falling edge seen while `ready` is 1 gives exactly one `slot_valid` pulse, with `slot_bit` equal to the filtered line level `SMP` cycles after the edge. `SMP` is 30 at standard speed and 12 at fast speed. A write slot held low 10 cycles reads 1; held low 60 (standard) or 30 (fast) it reads 0.
- R8: If `rd_en`=1 and `rd_bit`=0 when the slot starts, `bus_drive_low` is 1 for exactly `HOLD` cycles (45 standard, 20 fast), and `slot_read`=1 with `slot_bit`=0. If `rd_bit`=1, the line is never driven.
- R9: A one-cycle pulse on `od_set` sets `od_mode` to 1 on the next cycle. The fast timing values apply from then on.
- R10: A low pulse shorter than `FILT` (3) cycles is ignored: there is no slot, no drive and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous-assert, active-low block reset |
| bus_in | input | 1 | Raw bus level (1 = released) |
| bus_drive_low | output | 1 | Open-drain enable: 1 pulls the bus low |
| od_set | input | 1 | Pulse from the layer above that selects fast timing |
| od_mode | output | 1 | Current speed: 1 = fast timing |
| ready | output | 1 | Presence sequence finished; slots are accepted |
| rst_seen | output | 1 | One-cycle pulse when a bus reset is recognised |
| rd_en | input | 1 | The coming slot is a read slot |
| rd_bit | input | 1 | Bit to send in a read slot |
| slot_valid | output | 1 | One-cycle strobe at the sample point of a slot |
| slot_bit | output | 1 | Line level sampled in the slot |
| slot_read | output | 1 | The strobed slot was a read slot |

## Verification
The input path is two synchroniser flops, a three-deep filter and an edge register. Every bus change therefore reaches the state machines six edges after the bench drives it. The `rst_seen` strobe shows up six cycles after the release, and the presence drive begins `PDH+7` cycles after it. The bench drives the bus on falling clock edges and samples on the same edges, before it changes its stimulus. It keeps an index per cycle, so these arrival points are checked against exact cycle numbers. For slots, the bench watches a window that lasts well past the hold time. It counts strobes and drive cycles inside that window, so the one-strobe and exact-hold rules are checked whatever the sample cycle is.

// File: rtl/scb_pkg.sv
package scb_pkg;

  typedef enum logic [1:0] {
    RC_NONE,
    RC_KEEP,
    RC_STD
  } rst_cls_e;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_WAIT,
    PS_LOW,
    PS_REC
  } pres_st_e;

  // Pick a timing value from the current speed.
  function automatic int unsigned f_pick(input logic fast, input int unsigned slow_v,
                                         input int unsigned fast_v);
    return fast ? fast_v : slow_v;
  endfunction

  // Sort a finished low pulse into no reset, a reset that keeps fast speed,
  // or a reset that returns to standard speed.
  function automatic rst_cls_e f_classify(input logic fast, input int unsigned low,
                                          input int unsigned long_min,
                                          input int unsigned fast_min,
                                          input int unsigned fast_keep);
    if (low >= long_min) return RC_STD;
    if (fast && low >= fast_min) return (low <= fast_keep) ? RC_KEEP : RC_STD;
    return RC_NONE;
  endfunction

endpackage

// File: rtl/scb_in_cond.sv
module scb_in_cond #(
  parameter int unsigned SYNC = 2,
  parameter int unsigned FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic line,
  output logic fall,
  output logic rise
);
  logic [SYNC-1:0] sync_q;
  logic [FILT-1:0] hist_q;
  logic            line_q;
  logic            prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      line_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin};
      hist_q <= {hist_q[FILT-2:0], sync_q[SYNC-1]};
      if (&hist_q)       line_q <= 1'b1;
      else if (~|hist_q) line_q <= 1'b0;
      prev_q <= line_q;
    end
  end

  assign line = line_q;
  assign fall = prev_q & ~line_q;
  assign rise = ~prev_q & line_q;

  // R10: a filtered edge needs FILT equal synchroniser samples behind it
  a_r10_filtered_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(line_q) |-> (line_q == $past(sync_q[SYNC-1])));
endmodule

// File: rtl/scb_rst_det.sv
module scb_rst_det
  import scb_pkg::*;
#(
  parameter int unsigned CW         = 10,
  parameter int unsigned RST_LONG   = 480,
  parameter int unsigned OD_RST_MIN = 48,
  parameter int unsigned OD_KEEP    = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic rise,
  input  logic od,
  output logic rst_evt,
  output logic rst_keep
);
  logic [CW-1:0] low_q;
  rst_cls_e      cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_q <= '0;
    else if (line)     low_q <= '0;
    else if (~&low_q)  low_q <= low_q + CW'(1);
  end

  always_comb begin
    cls = RC_NONE;
    if (rise) cls = f_classify(od, 32'(low_q), RST_LONG, OD_RST_MIN, OD_KEEP);
  end

  assign rst_evt  = (cls != RC_NONE);
  assign rst_keep = (cls == RC_KEEP);

  // R2: a reset is recognised only at the end of a low pulse
  a_r2_reset_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |-> (line && $past(!line)));
endmodule

// File: rtl/scb_presence.sv
module scb_presence
  import scb_pkg::*;
#(
  parameter int unsigned CW      = 10,
  parameter int unsigned PDH_STD = 30,
  parameter int unsigned PDH_OD  = 3,
  parameter int unsigned PDL_STD = 120,
  parameter int unsigned PDL_OD  = 12,
  parameter int unsigned REC_STD = 8,
  parameter int unsigned REC_OD  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_evt,
  input  logic od,
  output logic drive,
  output logic ready
);
  pres_st_e      st_q;
  logic [CW-1:0] tmr_q;
  logic          rdy_q;
  int unsigned   lim;
  logic          done;

  always_comb begin
    case (st_q)
      PS_WAIT: lim = f_pick(od, PDH_STD, PDH_OD);
      PS_LOW:  lim = f_pick(od, PDL_STD, PDL_OD);
      PS_REC:  lim = f_pick(od, REC_STD, REC_OD);
      default: lim = 1;
    endcase
  end

  assign done = (32'(tmr_q) >= lim - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      tmr_q <= '0;
      rdy_q <= 1'b0;
    end else if (rst_evt) begin
      st_q  <= PS_WAIT;
      tmr_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      case (st_q)
        PS_WAIT: begin
          if (done) begin st_q <= PS_LOW; tmr_q <= '0; end
          else tmr_q <= tmr_q + CW'(1);
        end
        PS_LOW: begin
          if (done) begin st_q <= PS_REC; tmr_q <= '0; end
          else tmr_q <= tmr_q + CW'(1);
        end
        PS_REC: begin
          if (done) begin st_q <= PS_IDLE; tmr_q <= '0; rdy_q <= 1'b1; end
          else tmr_q <= tmr_q + CW'(1);
        end
        default: tmr_q <= '0;
      endcase
    end
  end

  assign drive = (st_q == PS_LOW);
  assign ready = rdy_q;

  // R6: no slot acceptance while the presence pulse is on the line
  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> !ready);
  // R5: the presence pulse always follows a wait phase
  a_r5_low_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $past(st_q == PS_WAIT));
endmodule

// File: rtl/scb_slot.sv
module scb_slot
  import scb_pkg::*;
#(
  parameter int unsigned CW       = 10,
  parameter int unsigned SMP_STD  = 30,
  parameter int unsigned SMP_OD   = 12,
  parameter int unsigned HOLD_STD = 45,
  parameter int unsigned HOLD_OD  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic line,
  input  logic ready_i,
  input  logic abort,
  input  logic od,
  input  logic rd_en,
  input  logic rd_bit,
  output logic drive,
  output logic valid,
  output logic bit_o,
  output logic is_read
);
  logic          act_q;
  logic          drv0_q;
  logic          rd_q;
  logic [CW-1:0] tmr_q;
  int unsigned   smp;
  int unsigned   hold;
  int unsigned   last;

  always_comb begin
    smp  = f_pick(od, SMP_STD, SMP_OD);
    hold = f_pick(od, HOLD_STD, HOLD_OD);
    last = (smp > hold) ? smp : hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      drv0_q <= 1'b0;
      rd_q   <= 1'b0;
      tmr_q  <= '0;
    end else if (abort) begin
      act_q <= 1'b0;
      tmr_q <= '0;
    end else if (!act_q) begin
      if (fall && ready_i) begin
        act_q  <= 1'b1;
        tmr_q  <= '0;
        drv0_q <= rd_en & ~rd_bit;
        rd_q   <= rd_en;
      end
    end else begin
      if (32'(tmr_q) >= last) act_q <= 1'b0;
      tmr_q <= tmr_q + CW'(1);
    end
  end

  assign drive   = act_q && drv0_q && (32'(tmr_q) < hold);
  assign valid   = act_q && !abort && (32'(tmr_q) == smp);
  assign bit_o   = line;
  assign is_read = rd_q;

  // R8: the slave only starts pulling low right after a master edge
  a_r8_drive_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $past(fall));
  // R7: one strobe per slot
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R6: strobes only while ready
  a_r6_strobe_ready: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ready_i);
endmodule

// File: rtl/scb_slave_phy.sv
module scb_slave_phy
  import scb_pkg::*;
#(
  parameter int unsigned SYNC       = 2,
  parameter int unsigned FILT       = 3,
  parameter int unsigned RST_LONG   = 480,
  parameter int unsigned OD_RST_MIN = 48,
  parameter int unsigned OD_KEEP    = 80,
  parameter int unsigned PDH_STD    = 30,
  parameter int unsigned PDH_OD     = 3,
  parameter int unsigned PDL_STD    = 120,
  parameter int unsigned PDL_OD     = 12,
  parameter int unsigned REC_STD    = 8,
  parameter int unsigned REC_OD     = 8,
  parameter int unsigned SMP_STD    = 30,
  parameter int unsigned SMP_OD     = 12,
  parameter int unsigned HOLD_STD   = 45,
  parameter int unsigned HOLD_OD    = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic bus_drive_low,
  input  logic od_set,
  output logic od_mode,
  output logic ready,
  output logic rst_seen,
  input  logic rd_en,
  input  logic rd_bit,
  output logic slot_valid,
  output logic slot_bit,
  output logic slot_read
);
  localparam int unsigned CW = $clog2(RST_LONG + 1) + 1;

  logic line_f;
  logic fall_evt;
  logic rise_evt;
  logic rst_evt;
  logic rst_keep;
  logic pres_drive;
  logic slot_drive;
  logic od_q;

  scb_in_cond #(.SYNC(SYNC), .FILT(FILT)) u_in (
    .clk(clk), .rst_n(rst_n), .pin(bus_in),
    .line(line_f), .fall(fall_evt), .rise(rise_evt)
  );

  scb_rst_det #(.CW(CW), .RST_LONG(RST_LONG), .OD_RST_MIN(OD_RST_MIN), .OD_KEEP(OD_KEEP)) u_rst (
    .clk(clk), .rst_n(rst_n), .line(line_f), .rise(rise_evt), .od(od_q),
    .rst_evt(rst_evt), .rst_keep(rst_keep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       od_q <= 1'b0;
    else if (rst_evt) od_q <= rst_keep;
    else if (od_set)  od_q <= 1'b1;
  end

  scb_presence #(
    .CW(CW), .PDH_STD(PDH_STD), .PDH_OD(PDH_OD), .PDL_STD(PDL_STD), .PDL_OD(PDL_OD),
    .REC_STD(REC_STD), .REC_OD(REC_OD)
  ) u_pres (
    .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt), .od(od_q),
    .drive(pres_drive), .ready(ready)
  );

  scb_slot #(
    .CW(CW), .SMP_STD(SMP_STD), .SMP_OD(SMP_OD), .HOLD_STD(HOLD_STD), .HOLD_OD(HOLD_OD)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .fall(fall_evt), .line(line_f), .ready_i(ready),
    .abort(rst_evt), .od(od_q), .rd_en(rd_en), .rd_bit(rd_bit),
    .drive(slot_drive), .valid(slot_valid), .bit_o(slot_bit), .is_read(slot_read)
  );

  assign bus_drive_low = pres_drive | slot_drive;
  assign od_mode       = od_q;
  assign rst_seen      = rst_evt;

  // R5/R8: presence and read-slot drive never overlap
  a_r5_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(pres_drive && slot_drive));
  // R3: a short reset at fast speed keeps fast speed
  a_r3_keep_fast: assert property (@(posedge clk) disable iff (!rst_n)
    rst_keep |=> od_mode);
  // R4: any other reset returns to standard speed
  a_r4_back_to_std: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && !rst_keep) |=> !od_mode);
  // R9: the speed request takes effect on the next cycle
  a_r9_enter_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (od_set && !rst_evt) |=> od_mode);
endmodule

// File: tb/test_scb_slave_phy.sv
`timescale 1ns/1ps
module test_scb_slave_phy;
  localparam int LAT = 7;   // SYNC + FILT + 2 cycles from a bus change to the state machines

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic od_set = 1'b0;
  logic rd_en = 1'b0;
  logic rd_bit = 1'b0;
  logic bus_in, bus_drive_low, od_mode, ready, rst_seen, slot_valid, slot_bit, slot_read;
  int n_chk = 0;
  int n_fail = 0;
  bit cur_od = 1'b0;

  always #2 clk = ~clk;

  assign bus_in = ~(m_low | bus_drive_low);

  scb_slave_phy i_scb_slave_phy (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_drive_low(bus_drive_low),
    .od_set(od_set), .od_mode(od_mode), .ready(ready), .rst_seen(rst_seen),
    .rd_en(rd_en), .rd_bit(rd_bit), .slot_valid(slot_valid), .slot_bit(slot_bit),
    .slot_read(slot_read)
  );

  function automatic int f_pdh(bit f);  return f ? 3 : 30;   endfunction
  function automatic int f_pdl(bit f);  return f ? 12 : 120; endfunction
  function automatic int f_hold(bit f); return f ? 20 : 45;  endfunction
  function automatic int f_wlow(bit f); return f ? 30 : 60;  endfunction
  function automatic bit f_is_rst(bit f, int len);
    return (len >= 480) || (f && len >= 48);
  endfunction
  function automatic bit f_next_od(bit f, int len);
    if (!f_is_rst(f, len)) return f;
    return f && (len <= 80);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // One master slot: low for len cycles, then observe the window.
  task automatic do_slot(input int len, input bit rd, input bit b, input bit exp_v,
                         input string req);
    int nv = 0;
    int drv = 0;
    int got = -1;
    int gread = -1;
    rd_en = rd;
    rd_bit = b;
    for (int i = 0; i < len + 70; i++) begin
      @(negedge clk);
      if (bus_drive_low) drv++;
      if (slot_valid) begin nv++; got = int'(slot_bit); gread = int'(slot_read); end
      m_low = (i < len);
    end
    rd_en = 1'b0;
    rd_bit = 1'b0;
    chk(req, "strobe count", nv, exp_v ? 1 : 0);
    chk(req, "drive cycles", drv, (exp_v && rd && !b) ? f_hold(cur_od) : 0);
    if (exp_v) begin
      chk(req, "slot bit", got, int'(b));
      chk(req, "slot read flag", gread, int'(rd));
    end
  endtask

  // A long low pulse; checks reset recognition, presence and speed afterwards.
  task automatic do_reset(input int len, input string req);
    bit is_rst = f_is_rst(cur_od, len);
    bit nod = f_next_od(cur_od, len);
    int nrst = 0;
    int first = -1;
    int drv = 0;
    int rdy_at_pres = -1;
    for (int i = 0; i < len + 200; i++) begin
      @(negedge clk);
      if (i > len) begin
        if (rst_seen) nrst++;
        if (bus_drive_low) begin
          drv++;
          if (first < 0) begin first = i - len; rdy_at_pres = int'(ready); end
        end
      end
      m_low = (i < len);
    end
    chk(req, "reset strobe count", nrst, is_rst ? 1 : 0);
    chk(req, "speed after pulse", int'(od_mode), int'(nod));
    chk("R6", "ready after pulse", int'(ready), 1);
    if (is_rst) begin
      chk("R5", "presence start", first, LAT + f_pdh(nod));
      chk("R5", "presence length", drv, f_pdl(nod));
      chk("R6", "ready during presence", rdy_at_pres, 0);
    end else begin
      chk(req, "no presence drive", drv, 0);
    end
    cur_od = nod;
  endtask

  task automatic go_fast();
    @(negedge clk);
    od_set = 1'b1;
    @(negedge clk);
    od_set = 1'b0;
    chk("R9", "speed after request", int'(od_mode), 1);
    cur_od = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    // R1: state after block reset
    chk("R1", "od_mode", int'(od_mode), 0);
    chk("R1", "ready", int'(ready), 0);
    chk("R1", "drive", int'(bus_drive_low), 0);
    // R1/R6: slots before the first bus reset are ignored
    do_slot(10, 1'b0, 1'b1, 1'b0, "R6");
    // R2: standard reset
    do_reset(500, "R2");
    // R7: writes at standard speed
    do_slot(10, 1'b0, 1'b1, 1'b1, "R7");
    do_slot(60, 1'b0, 1'b0, 1'b1, "R7");
    // R8: reads at standard speed
    do_slot(10, 1'b1, 1'b0, 1'b1, "R8");
    do_slot(10, 1'b1, 1'b1, 1'b1, "R8");
    // R10: glitch shorter than the filter
    do_slot(2, 1'b1, 1'b0, 1'b0, "R10");
    // R2: boundary just below and at the long reset
    do_reset(479, "R2");
    do_reset(480, "R2");
    // R9 then fast slots
    go_fast();
    do_slot(10, 1'b0, 1'b1, 1'b1, "R7");
    do_slot(30, 1'b0, 1'b0, 1'b1, "R7");
    do_slot(10, 1'b1, 1'b0, 1'b1, "R8");
    // R3: short resets keep fast speed
    do_reset(60, "R3");
    do_reset(80, "R3");
    do_reset(48, "R3");
    // R4: pulse just below the fast reset minimum is a slot
    do_reset(47, "R4");
    // R4: middle band returns to standard speed
    do_reset(81, "R4");
    go_fast();
    do_reset(500, "R4");
    // random slots at both speeds
    for (int n = 0; n < 40; n++) begin
      bit rd;
      bit b;
      int len;
      if (n == 20) go_fast();
      rd = 1'($urandom_range(0, 1));
      b = 1'($urandom_range(0, 1));
      len = (rd || b) ? 10 : f_wlow(cur_od);
      do_slot(len, rd, b, 1'b1, rd ? "R8" : "R7");
    end
    summary();
    $finish;
  end
endmodule